// File: doc/BRIEF.md
# PLL Reset and Lock Sequencer

This block walks a clock-multiplying PLL from power-up to its locked, in-use state. It holds the PLL in reset through a power-up settling interval. It then keeps the PLL reset asserted for a minimum hold time and releases it. Next it waits a minimum number of input-clock periods for lock. Only after that may it move the system clock mux from the raw input clock (bypass) to the PLL output. All intervals are counted in input-clock cycles. Each count is the required time divided by the clock period parameter, rounded up.

Software works through a small write/read register port. It can request PLL mode, request a fresh PLL reset, and program the pre-divider and multiplier word. A change to the divider word drops the clock back to bypass and replays the reset and lock steps. A request for PLL mode made before lock is reached is kept and carried out when the lock count runs out. A busy output tells the host to hold off accesses while the clocks are being changed. A one-cycle done pulse marks each entry into PLL mode.

Top module: `pll_seq_ctrl`

## Requirements
- R1: `clk_sel` is 0 (bypass) from reset and is 1 only while the block is in PLL mode.
- R2: After reset release, `pll_rst` stays 1 for STAB_CYC = ceil(100000 / CLK_PERIOD_NS) cycles (12500 at 8 ns), followed by the reset hold. A reset request written during this interval does not shorten or restart it.
- R3: Each reset hold keeps `pll_rst` at 1 for RHOLD_CYC = ceil(1000 / CLK_PERIOD_NS) cycles (125 at 8 ns). A reset request is a write to address 0 with bit 1 = 1. Outside power-up settling, such a request starts a new hold at the write edge. Made during a hold, it restarts that hold.
- R4: `clk_sel` never rises earlier than LOCK_CYC = 2000 cycles after `pll_rst` falls.
- R5: A PLL-mode request is a write to address 0 with bit 0 = 1. If made before the lock count expires, it is kept. `clk_sel` then rises exactly LOCK_CYC cycles after `pll_rst` fell.
- R6: Once locked, writing bit 0 = 1 to address 0 raises `clk_sel` at the write edge. Writing bit 0 = 0 in PLL mode lowers `clk_sel` at the write edge while `pll_rst` stays 0.
- R7: A write to address 1 whose value differs from the stored divider word forces bypass. Outside power-up settling, it starts a new reset hold at the write edge, or restarts one already running. A write of the identical value has no effect.
- R8: `busy` (also status bit 0) is 1 during power-up settling, reset hold and lock wait, and 0 otherwise.
- R9: `done` is a single-cycle pulse, raised in the same cycle as each rise of `clk_sel`.
- R10: Read-back works as follows. Address 0 gives bit 1 = PLL reset active and bit 0 = stored PLL-mode request. Address 1 gives the divider word, with the pre-divider in bits [4:0] and the multiplier in bits [13:8]. Address 2 gives bit 2 = locked, bit 1 = `clk_sel` and bit 0 = `busy`. `pll_prediv` and `pll_mult` equal the stored fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input reference clock; all counts are in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 divider) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address (0 control, 1 divider, 2 status) |
| rd_data | output | 16 | Read data, combinational from `rd_addr` |
| pll_rst | output | 1 | Reset to the analog PLL, active high |
| clk_sel | output | 1 | Clock mux select: 0 input clock, 1 PLL output |
| pll_prediv | output | 5 | Pre-divider setting to the PLL |
| pll_mult | output | 6 | Multiplier setting to the PLL |
| busy | output | 1 | Host hold-off: clocks are being changed |
| done | output | 1 | One-cycle pulse on entry to PLL mode |

## Verification
The sequencing is exercised through several distinct paths:
- the power-up path, with the mode request and divider written early;
- a divider change while in PLL mode;
- a software reset request followed by a second request inside the hold;
- a mode request made in the middle of the lock wait;
- leaving and re-entering PLL mode while locked;
- a divider change in the middle of a reset hold.

A scoreboard predicts the exact cycle of every edge on `pll_rst` and `clk_sel` and of every `done` pulse. This separates a sequencer that restarts its timer from one that merely extends it. It also separates an early or late mode switch from one taken at the lock boundary. Two further checks cover the no-effect cases: the divider write of an identical value, and the reset request during power-up settling. Both must leave the predicted edge schedule untouched.

// File: rtl/pllseq_pkg.sv
`timescale 1ns/1ps
package pllseq_pkg;

  typedef enum logic [2:0] {
    ST_STAB   = 3'd0,
    ST_RHOLD  = 3'd1,
    ST_LOCKW  = 3'd2,
    ST_LOCKED = 3'd3,
    ST_PLLON  = 3'd4
  } seq_state_t;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_DIV  = 2'd1;
  localparam logic [1:0] ADR_STAT = 2'd2;

  function automatic int unsigned ceil_cycles(input int unsigned span_ns,
                                              input int unsigned per_ns);
    return (span_ns + per_ns - 1) / per_ns;
  endfunction

endpackage

// File: rtl/pllseq_regs.sv
`timescale 1ns/1ps
module pllseq_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          en_nxt,
  output logic          en_q,
  output logic          rst_req,
  output logic          div_chg,
  output logic [DW-1:0] div_q
);
  import pllseq_pkg::*;

  logic wr_ctrl;
  logic wr_div;
  logic en_d;

  assign wr_ctrl = wr_en && (wr_addr == ADR_CTRL);
  assign wr_div  = wr_en && (wr_addr == ADR_DIV);

  always_comb begin
    en_d = en_q;
    if (wr_ctrl) en_d = wr_data[0];
  end

  assign en_nxt  = en_d;
  assign rst_req = wr_ctrl && wr_data[1];
  assign div_chg = wr_div && (wr_data != div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else begin
      if (wr_ctrl) en_q  <= en_d;
      if (wr_div)  div_q <= wr_data;
    end
  end

  AST_DIV_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> $stable(div_q)); // R10

endmodule

// File: rtl/pllseq_timer.sv
`timescale 1ns/1ps
module pllseq_timer #(
  parameter int          CW   = 14,
  parameter int unsigned INIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          cnt_zero
);
  localparam logic [CW-1:0] INIT_V = CW'(INIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT_V;
    else        cnt_q <= cnt_d;
  end

  assign cnt_zero = (cnt_q == '0);

  AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !load) |=> cnt_zero); // R4

endmodule

// File: rtl/pllseq_fsm.sv
`timescale 1ns/1ps
module pllseq_fsm #(
  parameter int          CW        = 14,
  parameter int unsigned RHOLD_CYC = 125,
  parameter int unsigned LOCK_CYC  = 2000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   t_zero,
  input  logic                   en_nxt,
  input  logic                   rst_req,
  input  logic                   div_chg,
  output logic                   t_load,
  output logic [CW-1:0]          t_val,
  output logic                   pll_rst,
  output logic                   clk_sel,
  output logic                   busy,
  output logic                   locked,
  output logic                   done_q
);
  import pllseq_pkg::*;

  localparam logic [CW-1:0] RH_LD = CW'(RHOLD_CYC - 1);
  localparam logic [CW-1:0] LK_LD = CW'(LOCK_CYC - 1);

  seq_state_t state_q;
  seq_state_t state_d;
  logic       restart;
  logic       done_d;

  assign restart = rst_req || div_chg;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    case (state_q)
      ST_STAB: begin
        if (t_zero) begin
          state_d = ST_RHOLD;
          t_load  = 1'b1;
          t_val   = RH_LD;
        end
      end
      ST_RHOLD: begin
        if (restart) begin
          t_load = 1'b1;
          t_val  = RH_LD;
        end else if (t_zero) begin
          state_d = ST_LOCKW;
          t_load  = 1'b1;
          t_val   = LK_LD;
        end
      end
      ST_LOCKW: begin
        if (restart) begin
          state_d = ST_RHOLD;
          t_load  = 1'b1;
          t_val   = RH_LD;
        end else if (t_zero) begin
          if (en_nxt) state_d = ST_PLLON;
          else        state_d = ST_LOCKED;
        end
      end
      ST_LOCKED: begin
        if (restart) begin
          state_d = ST_RHOLD;
          t_load  = 1'b1;
          t_val   = RH_LD;
        end else if (en_nxt) begin
          state_d = ST_PLLON;
        end
      end
      ST_PLLON: begin
        if (restart) begin
          state_d = ST_RHOLD;
          t_load  = 1'b1;
          t_val   = RH_LD;
        end else if (!en_nxt) begin
          state_d = ST_LOCKED;
        end
      end
      default: state_d = ST_STAB;
    endcase
  end

  assign done_d = (state_d == ST_PLLON) && (state_q != ST_PLLON);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STAB;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign pll_rst = (state_q == ST_STAB) || (state_q == ST_RHOLD);
  assign busy    = pll_rst || (state_q == ST_LOCKW);
  assign clk_sel = (state_q == ST_PLLON);
  assign locked  = (state_q == ST_LOCKED) || (state_q == ST_PLLON);

  AST_BUSY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !clk_sel); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_RESTART_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && (state_q != ST_STAB)) |=> (pll_rst && !clk_sel)); // R7

endmodule

// File: rtl/pll_seq_ctrl.sv
`timescale 1ns/1ps
module pll_seq_ctrl #(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned STAB_NS       = 100000,
  parameter int unsigned RHOLD_NS      = 1000,
  parameter int unsigned LOCK_PERIODS  = 2000,
  parameter int          DW            = 16,
  parameter int          PDIV_W        = 5,
  parameter int          MULT_W        = 6,
  parameter int          MULT_LSB      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              pll_rst,
  output logic              clk_sel,
  output logic [PDIV_W-1:0] pll_prediv,
  output logic [MULT_W-1:0] pll_mult,
  output logic              busy,
  output logic              done
);
  import pllseq_pkg::*;

  localparam int unsigned STAB_CYC  = ceil_cycles(STAB_NS, CLK_PERIOD_NS);
  localparam int unsigned RHOLD_CYC = ceil_cycles(RHOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned LOCK_CYC  = LOCK_PERIODS;
  localparam int unsigned MAX_AB    = (STAB_CYC > RHOLD_CYC) ? STAB_CYC : RHOLD_CYC;
  localparam int unsigned MAX_CYC   = (MAX_AB > LOCK_CYC) ? MAX_AB : LOCK_CYC;
  localparam int          CW        = $clog2(MAX_CYC + 1);
  localparam int          HW        = $clog2(RHOLD_CYC + 1);
  localparam int          LW        = $clog2(LOCK_CYC + 1);

  logic          en_nxt;
  logic          en_q;
  logic          rst_req;
  logic          div_chg;
  logic [DW-1:0] div_q;
  logic          t_zero;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          locked;

  pllseq_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .en_nxt  (en_nxt),
    .en_q    (en_q),
    .rst_req (rst_req),
    .div_chg (div_chg),
    .div_q   (div_q)
  );

  pllseq_timer #(.CW(CW), .INIT(STAB_CYC - 1)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .cnt_zero (t_zero)
  );

  pllseq_fsm #(.CW(CW), .RHOLD_CYC(RHOLD_CYC), .LOCK_CYC(LOCK_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .t_zero  (t_zero),
    .en_nxt  (en_nxt),
    .rst_req (rst_req),
    .div_chg (div_chg),
    .t_load  (t_load),
    .t_val   (t_val),
    .pll_rst (pll_rst),
    .clk_sel (clk_sel),
    .busy    (busy),
    .locked  (locked),
    .done_q  (done)
  );

  assign pll_prediv = div_q[PDIV_W-1:0];
  assign pll_mult   = div_q[MULT_LSB +: MULT_W];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL: rd_data[1:0] = {pll_rst, en_q};
      ADR_DIV:  rd_data      = div_q;
      ADR_STAT: rd_data[2:0] = {locked, clk_sel, busy};
      default:  rd_data      = '0;
    endcase
  end

  // Interval checkers: saturating counts of cycles with reset high and since release
  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] rel_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      rel_cnt <= '0;
    end else begin
      if (!pll_rst)                      hi_cnt <= '0;
      else if (hi_cnt != HW'(RHOLD_CYC)) hi_cnt <= hi_cnt + 1'b1;
      if (pll_rst)                       rel_cnt <= '0;
      else if (rel_cnt != LW'(LOCK_CYC)) rel_cnt <= rel_cnt + 1'b1;
    end
  end

  AST_RESET_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst) |-> (hi_cnt >= HW'(RHOLD_CYC))); // R3
  AST_LOCK_WAIT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> (rel_cnt >= LW'(LOCK_CYC))); // R4
  AST_DONE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> done); // R9
  AST_SEL_NEEDS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |-> !pll_rst); // R1

endmodule

// File: tb/sim_pll_seq_ctrl.sv
`timescale 1ns/1ps
module sim_pll_seq_ctrl;

  localparam int SC = (100000 + 7) / 8;
  localparam int RC = (1000 + 7) / 8;
  localparam int LC = 2000;

  localparam int EV_RRISE = 1;
  localparam int EV_RFALL = 2;
  localparam int EV_SRISE = 3;
  localparam int EV_SFALL = 4;
  localparam int EV_DONE  = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;
  logic        pll_rst;
  logic        clk_sel;
  logic [4:0]  pll_prediv;
  logic [5:0]  pll_mult;
  logic        busy;
  logic        done;

  int nchk  = 0;
  int nfail = 0;
  int cyc;
  bit mon_on = 1'b0;
  logic p_rst, p_sel, p_done;

  int    exp_kind[$];
  int    exp_cyc[$];
  string exp_tag[$];

  always #4 clk = ~clk;

  pll_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pll_rst(pll_rst), .clk_sel(clk_sel),
    .pll_prediv(pll_prediv), .pll_mult(pll_mult), .busy(busy), .done(done)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int at, input string tag);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
    exp_tag.push_back(tag);
  endtask

  task automatic observe(input int kind);
    int ek, ec;
    string et;
    nchk++;
    if (exp_kind.size() == 0) begin
      nfail++;
      $display("FAIL R1 unexpected edge: act=kind %0d at %0d exp=none", kind, cyc);
    end else begin
      ek = exp_kind.pop_front();
      ec = exp_cyc.pop_front();
      et = exp_tag.pop_front();
      if (ek != kind || ec != cyc) begin
        nfail++;
        $display("FAIL %s edge: act=kind %0d at %0d exp=kind %0d at %0d", et, kind, cyc, ek, ec);
      end
    end
  endtask

  // Monitor: pops the scoreboard on every output edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (pll_rst !== p_rst) observe(pll_rst ? EV_RRISE : EV_RFALL);
      if (clk_sel !== p_sel) observe(clk_sel ? EV_SRISE : EV_SFALL);
      if (done === 1'b1 && p_done !== 1'b1) observe(EV_DONE);
    end
    p_rst  = pll_rst;
    p_sel  = clk_sel;
    p_done = done;
  end

  task automatic drive_wr(input logic [1:0] a, input logic [15:0] d, output int e);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    e = cyc + 1;
  endtask

  task automatic release_wr();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: act=running exp=finished");
    report();
  end

  initial begin
    int e, e2, e3, e4;
    logic [15:0] v;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 select after reset", clk_sel, 0);
    chk("R2 PLL reset after reset", pll_rst, 1);
    chk("R8 busy after reset", busy, 1);
    chk("R9 no done after reset", done, 0);
    rd(2'd0, v); chk("R10 control readback at reset", v, 16'h0002);
    rd(2'd1, v); chk("R10 divider readback at reset", v, 16'h0000);
    rd(2'd2, v); chk("R10 status readback at reset", v, 16'h0001);
    mon_on = 1'b1;

    // power-up path: reset request ignored, divider and mode written early
    drive_wr(2'd0, 16'h0002, e); release_wr();
    drive_wr(2'd1, 16'h1403, e); release_wr();
    drive_wr(2'd0, 16'h0001, e); release_wr();
    chk("R10 prediv field", pll_prediv, 3);
    chk("R10 mult field", pll_mult, 20);
    rd(2'd1, v); chk("R10 divider readback", v, 16'h1403);
    rd(2'd0, v); chk("R10 control readback", v, 16'h0003);
    expect_ev(EV_RFALL, SC + RC, "R2");
    expect_ev(EV_SRISE, SC + RC + LC, "R5");
    expect_ev(EV_DONE,  SC + RC + LC, "R9");
    wait_until(SC + RC + 100);
    chk("R8 busy in lock wait", busy, 1);
    wait_until(SC + RC + LC - 1);
    chk("R4 no select before lock", clk_sel, 0);
    wait_until(SC + RC + LC + 1);
    chk("R8 idle in PLL mode", busy, 0);
    rd(2'd2, v); chk("R10 status in PLL mode", v, 16'h0006);

    // identical divider write: no effect
    drive_wr(2'd1, 16'h1403, e); release_wr();
    repeat (20) @(negedge clk);
    chk("R7 select kept on same divider", clk_sel, 1);
    chk("R1 PLL mode select", clk_sel, 1);
    chk("R7 reset kept low on same divider", pll_rst, 0);

    // divider change in PLL mode
    drive_wr(2'd1, 16'h1503, e);
    expect_ev(EV_RRISE, e, "R7");
    expect_ev(EV_SFALL, e, "R7");
    expect_ev(EV_RFALL, e + RC, "R3");
    expect_ev(EV_SRISE, e + RC + LC, "R5");
    expect_ev(EV_DONE,  e + RC + LC, "R9");
    release_wr();
    chk("R10 new mult field", pll_mult, 21);
    wait_until(e + 20);
    chk("R8 busy in reset hold", busy, 1);
    wait_until(e + RC + LC + 2);

    // leave PLL mode, then reset request twice
    drive_wr(2'd0, 16'h0000, e);
    expect_ev(EV_SFALL, e, "R6");
    release_wr();
    chk("R6 reset stays low on leaving", pll_rst, 0);
    rd(2'd2, v); chk("R6 status locked bypass", v, 16'h0004);
    drive_wr(2'd0, 16'h0002, e2);
    expect_ev(EV_RRISE, e2, "R3");
    release_wr();
    wait_until(e2 + 50);
    drive_wr(2'd0, 16'h0002, e3); release_wr();
    expect_ev(EV_RFALL, e3 + RC, "R3");
    wait_until(e3 + RC + 300);
    drive_wr(2'd0, 16'h0001, e); release_wr();
    expect_ev(EV_SRISE, e3 + RC + LC, "R5");
    expect_ev(EV_DONE,  e3 + RC + LC, "R9");
    wait_until(e3 + RC + LC - 1);
    chk("R4 pending request waits", clk_sel, 0);
    wait_until(e3 + RC + LC + 2);

    // leave and re-enter while locked
    drive_wr(2'd0, 16'h0000, e);
    expect_ev(EV_SFALL, e, "R6");
    release_wr();
    repeat (10) @(negedge clk);
    drive_wr(2'd0, 16'h0001, e);
    expect_ev(EV_SRISE, e, "R6");
    expect_ev(EV_DONE,  e, "R9");
    release_wr();
    repeat (5) @(negedge clk);

    // divider change inside a reset hold
    drive_wr(2'd0, 16'h0003, e);
    expect_ev(EV_RRISE, e, "R3");
    expect_ev(EV_SFALL, e, "R3");
    release_wr();
    wait_until(e + 60);
    drive_wr(2'd1, 16'h1504, e4); release_wr();
    expect_ev(EV_RFALL, e4 + RC, "R7");
    expect_ev(EV_SRISE, e4 + RC + LC, "R5");
    expect_ev(EV_DONE,  e4 + RC + LC, "R9");
    wait_until(e4 + RC + LC + 5);

    chk("R1 all predicted edges seen", exp_kind.size(), 0);
    report();
  end

endmodule